// File: doc/BRIEF.md
# Bidirectional 128-bit Hardware Mailbox

This block carries 128-bit notifications between a host processor and an I/O coprocessor. It holds two independent queues, one per direction. Each message moves as two 64-bit halves. The first half, called lo, occupies message bits [63:0]. The second half, called hi, occupies bits [127:64]. The mailbox never interprets lo. By convention, the low byte of hi names a destination endpoint, and it is stored unchanged.

The host reaches the block through a 64-bit register port. Offsets are relative to the mailbox window. The host sends a message by writing lo to 0x800, where it waits in a staging register. Writing hi to 0x808 then commits the whole entry. The host receives a message by reading 0x830, which returns the head entry's lo and does not pop. Reading 0x838 returns the head entry's hi and pops the entry. Read data appears on `host_rdata_o` one cycle after the request.

The coprocessor side uses a plain push and pop port that carries whole 128-bit messages. The host has two interrupts:
- A send-done interrupt, raised once the coprocessor has drained the outbound queue.
- A receive interrupt, held while inbound messages are waiting.

Top module: `mbox_top`

## Requirements
- R1: A write to 0x800 alone enqueues nothing. A following write to 0x808 commits one entry {hi = 0x808 data, lo = staged 0x800 data}, and the coprocessor sees it at `cop_msg_o` with `cop_valid_o` high on the next cycle.
- R2: Each direction queues up to DEPTH (default 4) messages in first-in first-out order. A coprocessor push while `cop_full_o` is high is dropped.
- R3: A host commit at 0x808 while the outbound queue is full is dropped and sets a sticky overflow flag at status bit 0 of offset 0x110. Writing 1 to bit 0 of 0x110 clears that flag.
- R4: A read at 0x830 returns the head lo and leaves the queue unchanged. A read at 0x838 returns the head hi and pops the entry.
- R5: A read at 0x830 or 0x838 while the inbound queue is empty returns zero and does not move the queue pointers.
- R6: Offset 0x110 reports the outbound queue and 0x114 reports the inbound queue. In both, bit 17 = 1 means the queue is empty and bit 16 = 1 means it is not empty.
- R7: `irq_send_done_o` rises on the cycle after a coprocessor pop empties the outbound queue. It stays high until the host masks it or commits a new message. It is only ever high while the outbound queue is empty.
- R8: Bit 0 of offset 0x118 enables the send-done interrupt (1 at reset) and reads back. With the bit at 0 the output is low, but the pending condition is kept.
- R9: `irq_recv_o` is high exactly while the inbound queue holds at least one message.
- R10: Message bits pass through unchanged in both directions, including the endpoint byte at hi[7:0].
- R11: After reset both queues are empty, both interrupts are low, `cop_valid_o` is low and the overflow flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_req_i | input | 1 | Host access strobe |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 12 | Byte offset within the mailbox window |
| host_wdata_i | input | 64 | Host write data |
| host_rdata_o | output | 64 | Host read data, valid one cycle after the read |
| cop_push_i | input | 1 | Coprocessor enqueue to host |
| cop_msg_i | input | 128 | Message to enqueue |
| cop_full_o | output | 1 | Inbound queue full |
| cop_pop_i | input | 1 | Coprocessor dequeue of head message |
| cop_msg_o | output | 128 | Head of outbound queue |
| cop_valid_o | output | 1 | Outbound queue not empty |
| irq_send_done_o | output | 1 | Outbound queue drained interrupt |
| irq_recv_o | output | 1 | Inbound data pending interrupt |

## Verification
The assertions watch every cycle for four things:
- No queue count exceeds its depth.
- A pop on an empty queue leaves the count alone and a read on an empty queue returns zero.
- The overflow flag rises only after a dropped commit.
- The send-done interrupt is never high while outbound data is queued, and an accepted inbound push is always followed by the receive interrupt.

Only the directed scenarios can show the rest:
- Ordering and data integrity of queued messages, including the endpoint byte.
- Non-popping lo reads.
- Masking and the clear conditions of the send-done interrupt.
- The exact status encodings.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned HALF_W = 64;
  localparam int unsigned ADDR_W = 12;

  typedef logic [HALF_W-1:0] half_t;
  typedef struct packed {
    half_t hi;
    half_t lo;
  } msg_t;

  localparam logic [ADDR_W-1:0] OFS_TX_LO   = 12'h800;
  localparam logic [ADDR_W-1:0] OFS_TX_HI   = 12'h808;
  localparam logic [ADDR_W-1:0] OFS_RX_LO   = 12'h830;
  localparam logic [ADDR_W-1:0] OFS_RX_HI   = 12'h838;
  localparam logic [ADDR_W-1:0] OFS_STAT_TX = 12'h110;
  localparam logic [ADDR_W-1:0] OFS_STAT_RX = 12'h114;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 12'h118;

  localparam int unsigned ST_EMPTY_BIT  = 17;
  localparam int unsigned ST_NEMPTY_BIT = 16;
  localparam int unsigned ST_OVF_BIT    = 0;

  function automatic half_t status_word(input logic empty, input logic ovf);
    half_t w;
    w = '0;
    w[ST_EMPTY_BIT]  = empty;
    w[ST_NEMPTY_BIT] = ~empty;
    w[ST_OVF_BIT]    = ovf;
    return w;
  endfunction
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             drained_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             push_ok, pop_ok;

  assign empty_o   = (count_q == '0);
  assign full_o    = (count_q == CNT_W'(DEPTH));
  assign push_ok   = push_i & ~full_o;
  assign pop_ok    = pop_i & ~empty_o;
  assign data_o    = mem_q[rd_ptr_q];
  // last entry leaves with nothing arriving behind it
  assign drained_o = pop_ok & ~push_ok & (count_q == CNT_W'(1));

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));

  assert_empty_pop_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> (count_q == '0));

  assert_full_push_dropped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> full_o);
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_drained_i,
  input  logic tx_commit_i,
  input  logic send_en_i,
  input  logic rx_empty_i,
  output logic irq_send_done_o,
  output logic irq_recv_o
);
  logic done_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           done_pend_q <= 1'b0;
    else if (tx_commit_i)  done_pend_q <= 1'b0;
    else if (tx_drained_i) done_pend_q <= 1'b1;
  end

  assign irq_send_done_o = done_pend_q & send_en_i;
  assign irq_recv_o      = ~rx_empty_i;

  assert_done_from_drain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_pend_q) |-> $past(tx_drained_i));

  assert_done_cleared_by_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_commit_i |=> !irq_send_done_o);
endmodule

// File: rtl/mbox_top.sv
module mbox_top
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_req_i,
  input  logic          host_we_i,
  input  logic [11:0]   host_addr_i,
  input  logic [63:0]   host_wdata_i,
  output logic [63:0]   host_rdata_o,
  input  logic          cop_push_i,
  input  logic [127:0]  cop_msg_i,
  output logic          cop_full_o,
  input  logic          cop_pop_i,
  output logic [127:0]  cop_msg_o,
  output logic          cop_valid_o,
  output logic          irq_send_done_o,
  output logic          irq_recv_o
);
  localparam int unsigned MSG_W = 2 * HALF_W;

  logic  host_wr, host_rd, tx_commit, rx_pop;
  half_t stage_lo_q, rdata_q, rdata_d;
  logic  ovf_q, send_en_q;
  msg_t  tx_msg, rx_head;
  logic  tx_empty, tx_full, tx_drained;
  logic  rx_empty, rx_full, rx_drained_unused;

  assign host_wr   = host_req_i & host_we_i;
  assign host_rd   = host_req_i & ~host_we_i;
  assign tx_commit = host_wr & (host_addr_i == OFS_TX_HI);
  assign rx_pop    = host_rd & (host_addr_i == OFS_RX_HI) & ~rx_empty;
  assign tx_msg    = '{hi: host_wdata_i, lo: stage_lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_lo_q <= '0;
      ovf_q      <= 1'b0;
      send_en_q  <= 1'b1;
    end else begin
      if (host_wr && host_addr_i == OFS_TX_LO) stage_lo_q <= host_wdata_i;
      if (host_wr && host_addr_i == OFS_CTRL)  send_en_q  <= host_wdata_i[0];
      if (tx_commit && tx_full)
        ovf_q <= 1'b1;
      else if (host_wr && host_addr_i == OFS_STAT_TX && host_wdata_i[ST_OVF_BIT])
        ovf_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_d = '0;
    unique case (host_addr_i)
      OFS_RX_LO:   rdata_d = rx_empty ? '0 : rx_head.lo;
      OFS_RX_HI:   rdata_d = rx_empty ? '0 : rx_head.hi;
      OFS_STAT_TX: rdata_d = status_word(tx_empty, ovf_q);
      OFS_STAT_RX: rdata_d = status_word(rx_empty, 1'b0);
      OFS_CTRL:    rdata_d = half_t'(send_en_q);
      default:     rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (host_rd) rdata_q <= rdata_d;
  end
  assign host_rdata_o = rdata_q;

  mbox_fifo #(.DEPTH(DEPTH), .WIDTH(MSG_W)) u_tx_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (tx_commit),
    .data_i    (tx_msg),
    .pop_i     (cop_pop_i),
    .data_o    (cop_msg_o),
    .empty_o   (tx_empty),
    .full_o    (tx_full),
    .drained_o (tx_drained)
  );

  mbox_fifo #(.DEPTH(DEPTH), .WIDTH(MSG_W)) u_rx_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (cop_push_i),
    .data_i    (cop_msg_i),
    .pop_i     (rx_pop),
    .data_o    (rx_head),
    .empty_o   (rx_empty),
    .full_o    (rx_full),
    .drained_o (rx_drained_unused)
  );

  assign cop_full_o  = rx_full;
  assign cop_valid_o = ~tx_empty;

  mbox_irq_ctrl u_irq (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .tx_drained_i    (tx_drained),
    .tx_commit_i     (tx_commit),
    .send_en_i       (send_en_q),
    .rx_empty_i      (rx_empty),
    .irq_send_done_o (irq_send_done_o),
    .irq_recv_o      (irq_recv_o)
  );

  assert_overflow_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(tx_commit && tx_full));

  assert_send_done_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_send_done_o |-> !cop_valid_o);

  assert_recv_after_push_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cop_push_i && !cop_full_o) |=> irq_recv_o);

  assert_empty_read_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd && rx_empty && (host_addr_i == OFS_RX_LO || host_addr_i == OFS_RX_HI))
      |=> (host_rdata_o == '0));
endmodule

// File: tb/mbox_top_tb_top.sv
module mbox_top_tb_top;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_req = 1'b0, host_we = 1'b0;
  logic [11:0]   host_addr = '0;
  logic [63:0]   host_wdata = '0, host_rdata;
  logic          cop_push = 1'b0, cop_pop = 1'b0;
  logic [127:0]  cop_msg_in = '0, cop_msg_out;
  logic          cop_full, cop_valid, irq_done, irq_recv;
  int            n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  mbox_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .cop_push_i(cop_push), .cop_msg_i(cop_msg_in), .cop_full_o(cop_full),
    .cop_pop_i(cop_pop), .cop_msg_o(cop_msg_out), .cop_valid_o(cop_valid),
    .irq_send_done_o(irq_done), .irq_recv_o(irq_recv)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic hrd(input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    host_req = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    host_req = 1'b0;
    d = host_rdata;
  endtask

  task automatic cpush(input logic [127:0] m);
    @(negedge clk);
    cop_push = 1'b1; cop_msg_in = m;
    @(negedge clk);
    cop_push = 1'b0;
  endtask

  task automatic cpop(output logic [127:0] m);
    @(negedge clk);
    m = cop_msg_out;
    cop_pop = 1'b1;
    @(negedge clk);
    cop_pop = 1'b0;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    chk("R11 irq_send_done", 128'(irq_done), 128'(0));
    chk("R11 irq_recv", 128'(irq_recv), 128'(0));
    chk("R11 cop_valid", 128'(cop_valid), 128'(0));
    hrd(12'h110, d); chk("R11 R6 tx status", 128'(d), 128'h20000);
    hrd(12'h114, d); chk("R6 rx status", 128'(d), 128'h20000);
    hrd(12'h118, d); chk("R8 ctrl reset", 128'(d), 128'h1);
  endtask

  task automatic t_host_send();
    logic [63:0] d; logic [127:0] m;
    hwr(12'h800, 64'h1111_2222_3333_4444);
    chk("R1 lo alone no entry", 128'(cop_valid), 128'(0));
    hwr(12'h808, 64'h5555_6666_7777_8842);
    chk("R1 commit valid", 128'(cop_valid), 128'(1));
    chk("R1 R10 tx msg", cop_msg_out, {64'h5555_6666_7777_8842, 64'h1111_2222_3333_4444});
    hrd(12'h110, d); chk("R6 tx not empty", 128'(d), 128'h10000);
    cpop(m);
    chk("R7 send-done after drain", 128'(irq_done), 128'(1));
    repeat (3) @(negedge clk);
    chk("R7 send-done held", 128'(irq_done), 128'(1));
  endtask

  task automatic t_send_done_clear();
    logic [63:0] d; logic [127:0] m;
    hwr(12'h118, 64'h0);
    chk("R8 masked low", 128'(irq_done), 128'(0));
    hrd(12'h118, d); chk("R8 ctrl readback", 128'(d), 128'h0);
    hwr(12'h118, 64'h1);
    chk("R8 pending kept", 128'(irq_done), 128'(1));
    hwr(12'h800, 64'hAA);
    chk("R7 lo write keeps irq", 128'(irq_done), 128'(1));
    hwr(12'h808, 64'hBB);
    chk("R7 commit clears irq", 128'(irq_done), 128'(0));
    cpop(m);
    chk("R1 staged lo used", m, {64'hBB, 64'hAA});
    chk("R7 reasserts", 128'(irq_done), 128'(1));
  endtask

  task automatic t_order_overflow();
    logic [63:0] d; logic [127:0] m;
    for (int i = 1; i <= 5; i++) begin
      hwr(12'h800, 64'h100 + 64'(i));
      hwr(12'h808, {56'hE0, 8'(i)});
      if (i == 4) begin
        hrd(12'h110, d); chk("R3 no ovf at depth", 128'(d), 128'h10000);
      end
    end
    hrd(12'h110, d); chk("R3 ovf set", 128'(d), 128'h10001);
    for (int i = 1; i <= 4; i++) begin
      cpop(m);
      chk("R2 tx order", m, {56'hE0, 8'(i), 64'h100 + 64'(i)});
    end
    chk("R3 fifth dropped", 128'(cop_valid), 128'(0));
    hrd(12'h110, d); chk("R3 ovf sticky", 128'(d), 128'h20001);
    hwr(12'h110, 64'h1);
    hrd(12'h110, d); chk("R3 ovf cleared", 128'(d), 128'h20000);
  endtask

  task automatic t_recv();
    logic [63:0] d; logic [127:0] m;
    for (int k = 0; k < 3; k++)
      cpush({56'hA5A5_A5A5_A5A5_A5, 8'(8'h10 + k), 64'hC0DE_0000 + 64'(k)});
    chk("R9 recv irq high", 128'(irq_recv), 128'(1));
    hrd(12'h114, d); chk("R6 rx not empty", 128'(d), 128'h10000);
    for (int k = 0; k < 3; k++) begin
      hrd(12'h830, d); chk("R4 lo read", 128'(d), 128'(64'hC0DE_0000 + 64'(k)));
      hrd(12'h830, d); chk("R4 lo no pop", 128'(d), 128'(64'hC0DE_0000 + 64'(k)));
      hrd(12'h838, d);
      chk("R4 R10 hi with endpoint", 128'(d), 128'({56'hA5A5_A5A5_A5A5_A5, 8'(8'h10 + k)}));
    end
    chk("R9 recv irq low", 128'(irq_recv), 128'(0));
    hrd(12'h838, d); chk("R5 empty hi zero", 128'(d), 128'h0);
    hrd(12'h830, d); chk("R5 empty lo zero", 128'(d), 128'h0);
    hrd(12'h114, d); chk("R6 rx empty", 128'(d), 128'h20000);
    cpush({64'h77, 64'h66});
    hrd(12'h830, d); chk("R5 pointers intact", 128'(d), 128'h66);
    hrd(12'h838, d); chk("R5 pointers intact hi", 128'(d), 128'h77);
    m = '0;
  endtask

  task automatic t_cop_full();
    logic [63:0] d;
    for (int k = 1; k <= 5; k++) begin
      cpush({64'(k), 64'(k * 3)});
      if (k == 4) chk("R2 cop full", 128'(cop_full), 128'(1));
    end
    for (int k = 1; k <= 4; k++) begin
      hrd(12'h830, d); chk("R2 rx order lo", 128'(d), 128'(64'(k * 3)));
      hrd(12'h838, d); chk("R2 rx order hi", 128'(d), 128'(64'(k)));
    end
    chk("R2 fifth push dropped", 128'(irq_recv), 128'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_host_send();
    t_send_done_clear();
    t_order_overflow();
    t_recv();
    t_cop_full();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule